// File: doc/BRIEF.md
# Variable-Pulse-Width Bus Frame Receiver

This block decodes frames from a single-wire bus that encodes every symbol in the width and level of a pulse. It takes the bus level, already synchronised to the local clock, and a one-microsecond time-base tick. It measures how long each level lasts and sorts every completed pulse into a data bit, a frame delimiter or a normalization bit. From that it rebuilds the bytes of a frame, most significant bit first, and reports each one with a strobe.

A frame opens with a long high pulse and carries data bytes that end in a CRC byte. It may then show an end-of-data low gap, a normalization pulse and in-frame response bytes from another node. A long low period closes it. At frame close the block raises a one-cycle done pulse that carries a CRC verdict on the data part and an error flag. The error flag covers malformed timing, a byte cut short by a delimiter, and a frame longer than its byte limit. A static mode input divides every timing threshold by four for the four-times bus speed.

Top module: `vpw_frame_rx`

## Requirements
- R1: After reset every strobe output (rx_valid, frame_start, data_end, frame_done) is low, and so are frame_crc_ok and frame_error.
- R2: While idle, a high pulse whose width measures 164 to 239 ticks (41 to 59 in fast mode) gives one frame_start pulse and opens a frame. A high pulse of any other width while idle is ignored: it gives no strobe of any kind.
- R3: Inside a frame, a pulse of 34 to 95 ticks is short and one of 96 to 163 ticks is long. A short low or long high pulse is bit 0, and a long low or short high pulse is bit 1. Bits shift in most significant first, and every eighth bit gives one rx_valid pulse with the byte on rx_byte.
- R4: A low pulse of 164 to 239 ticks after whole data bytes gives one data_end pulse. The next high pulse must be short or long (the normalization bit). Bytes after it carry rx_in_resp = 1, and data bytes carry rx_in_resp = 0.
- R5: A low level that reaches 240 ticks (60 in fast mode) inside a frame, with no partial byte pending, ends the frame. It gives one frame_done pulse with frame_error = 0, and the receiver returns to idle.
- R6: The CRC is CRC-8 with polynomial x^8+x^4+x^3+x^2+1, preset to 0xFF and fed MSB first. It covers the data bytes including the sent CRC byte, but not the start pulse or the response bytes. frame_crc_ok is 1 at frame_done exactly when the remainder is 0xC4.
- R7: At most 12 bytes, data and response together, are accepted per frame. Completing a 13th byte emits no rx_valid and ends the frame with frame_done and frame_error = 1.
- R8: Inside a frame, a pulse below 34 ticks (8 fast), a high pulse of 164 ticks or more, or a delimiter that arrives mid-byte ends the frame. It gives frame_done with frame_error = 1 and frame_crc_ok = 0, and the receiver waits idle for the next start pulse.
- R9: With fast_mode = 1 every threshold is the normal one shifted right by two: 8, 24, 41 and 60 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond; width counting time base |
| fast_mode | input | 1 | 1 selects the four-times speed thresholds; change only while idle |
| bus_in | input | 1 | Synchronised bus level, idle low |
| rx_byte | output | 8 | Last received byte, valid with rx_valid |
| rx_valid | output | 1 | One-cycle strobe per received byte |
| rx_in_resp | output | 1 | With rx_valid: the byte belongs to the in-frame response |
| frame_start | output | 1 | One-cycle pulse when a start pulse is recognised |
| data_end | output | 1 | One-cycle pulse on end-of-data |
| frame_done | output | 1 | One-cycle pulse when the frame ends or is abandoned |
| frame_crc_ok | output | 1 | With frame_done: data CRC remainder was 0xC4 |
| frame_error | output | 1 | With frame_done: frame was malformed or too long |

## Verification
The bench targets a partial byte caught by a delimiter at both end-of-data and end-of-frame; a receiver that does not check its bit counter there would finish the frame cleanly with a shifted byte. It sends a thirteen-byte frame, where an off-by-one limit would either leak a 13th byte or cut off the 12th. It places a sub-minimum glitch mid-frame, and a stray long pulse on an idle bus, which a loose window would take as data or as a frame start. It also runs frames in both speed modes with and without in-frame responses, so that thresholds not scaled or a response flag set on data bytes show up as byte or CRC mismatches.

// File: rtl/vpw_rx_pkg.sv
// Package: shared types and CRC constants for the variable-pulse-width receiver.
// Assumes: CRC is fed one bit at a time, most significant bit first.
package vpw_rx_pkg;

    // Width class of a completed pulse; the level decides what it means
    typedef enum logic [1:0] {
        SYM_BAD   = 2'd0,
        SYM_SHORT = 2'd1,
        SYM_LONG  = 2'd2,
        SYM_DELIM = 2'd3
    } vpw_sym_e;

    // Frame reception phases
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DATA    = 2'd1,
        ST_NB_WAIT = 2'd2,
        ST_RESP    = 2'd3
    } rx_state_e;

    localparam logic [7:0] CRC_POLY   = 8'h1D;
    localparam logic [7:0] CRC_PRESET = 8'hFF;
    localparam logic [7:0] CRC_GOOD   = 8'hC4;

    // One CRC-8 step for a single incoming bit
    function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
        logic fb;
        fb = c[7] ^ b;
        return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    endfunction

endpackage

// File: rtl/vpw_pulse_timer.sv
// Module: measures how long the bus has held its current level.
// Registers the bus level once, flags a level change, and counts time-base
// ticks since the last change, saturating at the counter maximum.
// Assumes: bus_in is already synchronised to clk.
module vpw_pulse_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             bus_in,
    output logic             level_q,
    output logic             edge_now,
    output logic [CNT_W-1:0] width
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Level change seen between the registered and the incoming level
    assign edge_now = bus_in ^ level_q;

    // Track level and count ticks of the current pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            width   <= '0;
        end else begin
            level_q <= bus_in;
            if (edge_now)
                width <= '0;
            else if (us_tick && width != CNT_MAX)
                width <= width + 1'b1;
        end
    end

    // The counter must not wrap on a long idle period (end-of-frame detection)
    assert_width_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(width) == CNT_MAX && !$past(edge_now)) |-> width == CNT_MAX);

endmodule

// File: rtl/vpw_pulse_classifier.sv
// Module: sorts a measured pulse width into short, long, delimiter or bad,
// and flags when a width has reached the end-of-frame length.
// Thresholds sit midway between nominal widths; fast mode shifts every
// threshold right by FAST_SHIFT. Purely combinational.
module vpw_pulse_classifier
    import vpw_rx_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int MIN_W      = 34,
    parameter int LONG_W     = 96,
    parameter int DELIM_W    = 164,
    parameter int EOF_W      = 240,
    parameter int FAST_SHIFT = 2
) (
    input  logic             fast_mode,
    input  logic [CNT_W-1:0] width,
    output vpw_sym_e         sym,
    output logic             eof_hit
);

    localparam logic [CNT_W-1:0] N_MIN   = CNT_W'(MIN_W);
    localparam logic [CNT_W-1:0] N_LONG  = CNT_W'(LONG_W);
    localparam logic [CNT_W-1:0] N_DELIM = CNT_W'(DELIM_W);
    localparam logic [CNT_W-1:0] N_EOF   = CNT_W'(EOF_W);
    localparam logic [CNT_W-1:0] F_MIN   = CNT_W'(MIN_W >> FAST_SHIFT);
    localparam logic [CNT_W-1:0] F_LONG  = CNT_W'(LONG_W >> FAST_SHIFT);
    localparam logic [CNT_W-1:0] F_DELIM = CNT_W'(DELIM_W >> FAST_SHIFT);
    localparam logic [CNT_W-1:0] F_EOF   = CNT_W'(EOF_W >> FAST_SHIFT);

    logic [CNT_W-1:0] t_min, t_long, t_delim, t_eof;

    // Pick the threshold set for the active speed
    always_comb begin
        t_min   = fast_mode ? F_MIN   : N_MIN;
        t_long  = fast_mode ? F_LONG  : N_LONG;
        t_delim = fast_mode ? F_DELIM : N_DELIM;
        t_eof   = fast_mode ? F_EOF   : N_EOF;
    end

    // Compare the width against the ordered windows
    always_comb begin
        if (width < t_min)
            sym = SYM_BAD;
        else if (width < t_long)
            sym = SYM_SHORT;
        else if (width < t_delim)
            sym = SYM_LONG;
        else if (width < t_eof)
            sym = SYM_DELIM;
        else
            sym = SYM_BAD;
        eof_hit = (width >= t_eof);
    end

endmodule

// File: rtl/vpw_crc8.sv
// Module: bit-serial CRC-8 register, preset on clear, one bit per shift.
// Assumes: clear and shift are never requested in the same cycle.
module vpw_crc8
    import vpw_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       shift,
    input  logic       bit_in,
    output logic [7:0] crc
);

    // Preset or advance the remainder
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            crc <= CRC_PRESET;
        else if (shift)
            crc <= crc8_step(crc, bit_in);
    end

    // A new frame always starts from the all-ones preset
    assert_crc_preset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> crc == CRC_PRESET);

endmodule

// File: rtl/vpw_frame_rx.sv
// Module: frame receiver for a variable-pulse-width single-wire bus.
// Turns classified pulses into bytes, frame delimiters and frame status.
// Assumes: bus_in synchronised and idle low; us_tick one cycle per
// microsecond; fast_mode changed only while no frame is in progress.
module vpw_frame_rx
    import vpw_rx_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int MIN_W      = 34,
    parameter int LONG_W     = 96,
    parameter int DELIM_W    = 164,
    parameter int EOF_W      = 240,
    parameter int FAST_SHIFT = 2,
    parameter int MAX_BYTES  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic       fast_mode,
    input  logic       bus_in,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       rx_in_resp,
    output logic       frame_start,
    output logic       data_end,
    output logic       frame_done,
    output logic       frame_crc_ok,
    output logic       frame_error
);

    localparam int BC_W = $clog2(MAX_BYTES + 1);
    localparam logic [BC_W-1:0] BC_LIMIT = BC_W'(MAX_BYTES);

    logic             lvl_q;
    logic             pulse_end;
    logic [CNT_W-1:0] width;
    vpw_sym_e         sym;
    logic             eof_hit;
    logic [7:0]       crc;

    rx_state_e        state;
    logic [7:0]       shreg;
    logic [2:0]       bitcnt;
    logic [BC_W-1:0]  bytecnt;
    logic             crc_ok_lat;

    logic ev_start, ev_bit, ev_eod, ev_nb, ev_eof, ev_fail, ev_over;
    logic bit_val, is_data;
    logic [7:0] sh_next;

    vpw_pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .us_tick  (us_tick),
        .bus_in   (bus_in),
        .level_q  (lvl_q),
        .edge_now (pulse_end),
        .width    (width)
    );

    vpw_pulse_classifier #(
        .CNT_W(CNT_W), .MIN_W(MIN_W), .LONG_W(LONG_W),
        .DELIM_W(DELIM_W), .EOF_W(EOF_W), .FAST_SHIFT(FAST_SHIFT)
    ) u_class (
        .fast_mode (fast_mode),
        .width     (width),
        .sym       (sym),
        .eof_hit   (eof_hit)
    );

    vpw_crc8 u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ev_start),
        .shift  (ev_bit && state == ST_DATA),
        .bit_in (bit_val),
        .crc    (crc)
    );

    // Bit value from pulse level and width; next shift register content
    always_comb begin
        is_data = (sym == SYM_SHORT) || (sym == SYM_LONG);
        bit_val = lvl_q ^ (sym == SYM_LONG);
        sh_next = {shreg[6:0], bit_val};
    end

    // Decide what the pulse that just ended (or the idle timeout) means
    always_comb begin
        ev_start = 1'b0;
        ev_bit   = 1'b0;
        ev_eod   = 1'b0;
        ev_nb    = 1'b0;
        ev_eof   = 1'b0;
        ev_fail  = 1'b0;
        ev_over  = 1'b0;
        if (pulse_end) begin
            unique case (state)
                ST_IDLE: ev_start = lvl_q && (sym == SYM_DELIM);
                ST_DATA, ST_RESP: begin
                    if (is_data) begin
                        ev_bit  = 1'b1;
                        ev_over = (bitcnt == 3'd7) && (bytecnt == BC_LIMIT);
                    end else if (state == ST_DATA && !lvl_q && sym == SYM_DELIM
                                 && bitcnt == 3'd0) begin
                        ev_eod = 1'b1;
                    end else begin
                        ev_fail = 1'b1;
                    end
                end
                ST_NB_WAIT: begin
                    if (lvl_q && is_data)
                        ev_nb = 1'b1;
                    else
                        ev_fail = 1'b1;
                end
                default: ev_fail = 1'b0;
            endcase
        end else if (!lvl_q && eof_hit && (state == ST_DATA || state == ST_RESP)) begin
            if (bitcnt == 3'd0)
                ev_eof = 1'b1;
            else
                ev_fail = 1'b1;
        end
    end

    // Frame state, byte assembly and output strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            shreg        <= '0;
            bitcnt       <= '0;
            bytecnt      <= '0;
            crc_ok_lat   <= 1'b0;
            rx_byte      <= '0;
            rx_valid     <= 1'b0;
            rx_in_resp   <= 1'b0;
            frame_start  <= 1'b0;
            data_end     <= 1'b0;
            frame_done   <= 1'b0;
            frame_crc_ok <= 1'b0;
            frame_error  <= 1'b0;
        end else begin
            rx_valid    <= 1'b0;
            frame_start <= 1'b0;
            data_end    <= 1'b0;
            frame_done  <= 1'b0;
            if (ev_fail || ev_over) begin
                frame_done   <= 1'b1;
                frame_error  <= 1'b1;
                frame_crc_ok <= 1'b0;
                state        <= ST_IDLE;
            end else if (ev_start) begin
                frame_start <= 1'b1;
                state       <= ST_DATA;
                bitcnt      <= '0;
                bytecnt     <= '0;
                crc_ok_lat  <= 1'b0;
            end else if (ev_bit) begin
                shreg  <= sh_next;
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == 3'd7) begin
                    rx_byte    <= sh_next;
                    rx_valid   <= 1'b1;
                    rx_in_resp <= (state == ST_RESP);
                    bytecnt    <= bytecnt + 1'b1;
                end
            end else if (ev_eod) begin
                data_end   <= 1'b1;
                crc_ok_lat <= (crc == CRC_GOOD);
                state      <= ST_NB_WAIT;
            end else if (ev_nb) begin
                bitcnt <= '0;
                state  <= ST_RESP;
            end else if (ev_eof) begin
                frame_done   <= 1'b1;
                frame_error  <= 1'b0;
                frame_crc_ok <= (state == ST_DATA) ? (crc == CRC_GOOD) : crc_ok_lat;
                state        <= ST_IDLE;
            end
        end
    end

    // A frame can only open from idle
    assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> $past(state == ST_IDLE));

    // No byte beyond the frame limit is ever delivered
    assert_byte_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (bytecnt != '0 && bytecnt <= BC_LIMIT));

    // Strobes never coincide
    assert_single_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_start, rx_valid, data_end, frame_done}));

    // An abandoned frame never claims a good CRC
    assert_err_not_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_error) |-> !frame_crc_ok);

    // Response bytes only come after the normalization bit
    assert_resp_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_in_resp) |-> state == ST_RESP);

    // A clean frame end happens only on a low bus
    assert_done_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_error) |-> !$past(lvl_q));

endmodule

// File: tb/tb_vpw_frame_rx.sv
`timescale 1ns/1ps
module tb_vpw_frame_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b1;
    logic       fast_mode = 1'b0;
    logic       bus_in = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_valid, rx_in_resp, frame_start, data_end;
    logic       frame_done, frame_crc_ok, frame_error;

    vpw_frame_rx dut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .fast_mode(fast_mode),
        .bus_in(bus_in), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_in_resp(rx_in_resp), .frame_start(frame_start), .data_end(data_end),
        .frame_done(frame_done), .frame_crc_ok(frame_crc_ok), .frame_error(frame_error)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // Monitor counters (only written here)
    int n_bytes = 0, n_start = 0, n_eod = 0, n_done = 0;
    logic [7:0] got_b [0:255];
    logic       got_r [0:255];
    logic       last_ok = 0, last_err = 0;

    always @(negedge clk) begin
        if (rx_valid) begin
            if (n_bytes < 256) begin
                got_b[n_bytes] = rx_byte;
                got_r[n_bytes] = rx_in_resp;
            end
            n_bytes++;
        end
        if (frame_start) n_start++;
        if (data_end) n_eod++;
        if (frame_done) begin
            n_done++;
            last_ok  = frame_crc_ok;
            last_err = frame_error;
        end
    end

    logic [7:0] tx_buf [0:15];
    logic lvl;
    int b_bytes, b_start, b_eod, b_done;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_of(input int first, input int n);
        logic [7:0] c = 8'hFF;
        for (int i = first; i < first + n; i++)
            for (int k = 7; k >= 0; k--) begin
                logic fb = c[7] ^ tx_buf[i][k];
                c = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
            end
        return c;
    endfunction

    // Nominal width in ticks: 0 short, 1 long, 2 delimiter, 3 end-of-frame
    function automatic int nom(input int kind);
        int w;
        case (kind)
            0: w = 64;
            1: w = 128;
            2: w = 200;
            default: w = 300;
        endcase
        return fast_mode ? w / 4 : w;
    endfunction

    task automatic tx_pulse(input logic l, input int w);
        bus_in = l;
        repeat (w) @(negedge clk);
    endtask

    task automatic tx_kind(input logic l, input int kind);
        int j = fast_mode ? 3 : 20;
        int w = nom(kind);
        if (kind < 3) w = w + $urandom_range(0, 2 * j) - j;
        tx_pulse(l, w);
    endtask

    task automatic tx_bit(input logic b);
        tx_kind(lvl, (b ^ lvl) ? 1 : 0);
        lvl = ~lvl;
    endtask

    task automatic tx_bits(input logic [7:0] v, input int n);
        for (int k = 7; k > 7 - n; k--) tx_bit(v[k]);
    endtask

    task automatic tx_sof();
        tx_kind(1'b1, 2);
        lvl = 1'b0;
    endtask

    task automatic tx_eof();
        tx_kind(1'b0, 3);
        repeat (5) @(negedge clk);
    endtask

    task automatic mark();
        b_bytes = n_bytes; b_start = n_start; b_eod = n_eod; b_done = n_done;
    endtask

    // Whole frame: nd data bytes then optional nr response bytes
    task automatic send_frame(input int nd, input int nr, input bit nb_long);
        mark();
        tx_sof();
        for (int i = 0; i < nd; i++) tx_bits(tx_buf[i], 8);
        if (nr > 0) begin
            tx_kind(1'b0, 2);
            tx_kind(1'b1, nb_long ? 1 : 0);
            lvl = 1'b0;
            for (int i = nd; i < nd + nr; i++) tx_bits(tx_buf[i], 8);
        end
        tx_eof();
    endtask

    task automatic check_frame(input string req, input int nd, input int nr,
                               input int nout, input bit exp_err);
        bit exp_ok = !exp_err && (crc_of(0, nd) == 8'hC4);
        chk(n_start - b_start == 1, "R2", {req, " start count"}, n_start - b_start, 1);
        chk(n_bytes - b_bytes == nout, "R3", {req, " byte count"}, n_bytes - b_bytes, nout);
        for (int i = 0; i < nout && i < n_bytes - b_bytes; i++) begin
            chk(got_b[b_bytes + i] == tx_buf[i], "R3", {req, " byte value"},
                got_b[b_bytes + i], tx_buf[i]);
            chk(got_r[b_bytes + i] == (i >= nd), "R4", {req, " resp flag"},
                got_r[b_bytes + i], int'(i >= nd));
        end
        if (!exp_err)
            chk(n_eod - b_eod == (nr > 0 ? 1 : 0), "R4", {req, " data_end count"},
                n_eod - b_eod, nr > 0 ? 1 : 0);
        chk(n_done - b_done == 1, "R5", {req, " done count"}, n_done - b_done, 1);
        chk(last_err == exp_err, exp_err ? "R8" : "R5", {req, " error flag"},
            last_err, exp_err);
        chk(last_ok == exp_ok, "R6", {req, " crc ok"}, last_ok, exp_ok);
    endtask

    function automatic void seal(input int nd);
        tx_buf[nd - 1] = ~crc_of(0, nd - 1);
    endfunction

    initial begin
        void'($urandom(32'd5150));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk({rx_valid, frame_start, data_end, frame_done, frame_crc_ok, frame_error} == 6'b0,
            "R1", "outputs in reset", {rx_valid, frame_start, data_end, frame_done}, 0);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        chk({rx_valid, frame_start, data_end, frame_done} == 4'b0,
            "R1", "outputs after reset", {rx_valid, frame_start, data_end, frame_done}, 0);

        // R2: a long-bit-sized high pulse on an idle bus is ignored
        mark();
        tx_pulse(1'b1, 120);
        tx_pulse(1'b0, 300);
        chk(n_start == b_start && n_bytes == b_bytes && n_done == b_done && n_eod == b_eod,
            "R2", "idle noise strobes", n_start - b_start + n_done - b_done, 0);

        // R3 R5 R6: three-byte frame with good CRC
        tx_buf[0] = 8'hA5; tx_buf[1] = 8'h3C; seal(3);
        send_frame(3, 0, 0);
        check_frame("R6 good", 3, 0, 3, 0);

        // R6: corrupted CRC byte
        tx_buf[0] = 8'h01; tx_buf[1] = 8'hFE; seal(3); tx_buf[2] ^= 8'h10;
        send_frame(3, 0, 0);
        check_frame("R6 bad crc", 3, 0, 3, 0);

        // R4: data plus response after a long normalization bit
        tx_buf[0] = 8'h55; tx_buf[1] = 8'h80; seal(3); tx_buf[3] = 8'h9A;
        send_frame(3, 1, 1);
        check_frame("R4 resp", 3, 1, 4, 0);

        // R9: fast mode frame with response after a short normalization bit
        fast_mode = 1'b1;
        tx_buf[0] = 8'h00; tx_buf[1] = 8'hFF; tx_buf[2] = 8'h71; seal(4);
        tx_buf[4] = 8'h12; tx_buf[5] = 8'hEF;
        send_frame(4, 2, 0);
        check_frame("R9 fast", 4, 2, 6, 0);
        fast_mode = 1'b0;

        // R7: thirteen bytes, the last must be refused
        for (int i = 0; i < 13; i++) tx_buf[i] = 8'(8'h11 * i + 3);
        send_frame(13, 0, 0);
        check_frame("R7 overlong", 13, 0, 12, 1);

        // R8: partial byte at end of frame
        mark();
        tx_buf[0] = 8'hC3; tx_buf[1] = 8'hB0;
        tx_sof(); tx_bits(tx_buf[0], 8); tx_bits(tx_buf[1], 4); tx_eof();
        check_frame("R8 partial eof", 1, 0, 1, 1);

        // R8: partial byte at end of data
        mark();
        tx_buf[0] = 8'h6D; tx_buf[1] = 8'h40;
        tx_sof(); tx_bits(tx_buf[0], 8); tx_bits(tx_buf[1], 2);
        tx_kind(1'b0, 2); tx_kind(1'b1, 0); tx_eof();
        check_frame("R8 partial eod", 1, 0, 1, 1);
        chk(n_eod == b_eod, "R8", "no data_end on partial byte", n_eod - b_eod, 0);

        // R8: sub-minimum glitch inside a frame
        mark();
        tx_buf[0] = 8'h2E;
        tx_sof(); tx_bits(tx_buf[0], 8); tx_bit(1'b0);
        tx_pulse(1'b1, 20); tx_eof();
        check_frame("R8 glitch", 1, 0, 1, 1);

        // Random frames in both modes
        for (int f = 0; f < 6; f++) begin
            int nd = $urandom_range(2, 7);
            int nr = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 2) : 0;
            bit nbl = 1'($urandom_range(0, 1));
            fast_mode = 1'($urandom_range(0, 1));
            for (int i = 0; i < nd + nr; i++) tx_buf[i] = 8'($urandom);
            seal(nd);
            if ($urandom_range(0, 3) == 0) tx_buf[0] ^= 8'h04;
            send_frame(nd, nr, nbl);
            check_frame(fast_mode ? "R9 random" : "R3 random", nd, nr, nd + nr, 0);
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule